// File: doc/BRIEF.md
# Vector Gather Address Field Decoder

This block sits in an instruction decode pipeline. It turns the addressing bytes of a vector gather load into the fields that later stages use to form per-lane addresses. When a gather is issued, the front end pulses a start strobe along with the opcode, the three register-extension prefix bits and the destination and mask vector register numbers. The decoder then pulls the remaining bytes one at a time from a valid/ready byte stream. These are the ModRM byte, the mandatory scaled-index byte and zero, one or four displacement bytes.

In the scaled-index byte of a gather, the index field names a vector register rather than a general register. The decoder reports the base general register, or a flag saying there is no base. It also reports the 4-bit index vector register, the 2-bit scale, and the displacement sign-extended to `DISP_W` bits. Finally it gives a 4-bit selector that picks one of sixteen execution variants (index width, element width, scale). Any illegal encoding is reported in place of a result. This covers a non-gather opcode, a register-direct ModRM, a ModRM that omits the scaled-index byte, and a destination that collides with the index or the mask register. The decoder never pulls a byte it does not need.

Top module: `gvsib_decoder`

## Requirements
- R1: After reset, `byte_ready_o`, `done_o` and `illegal_o` are low, and all field outputs are zero.
- R2: An instruction is a gather only when opcode bits 7:2 equal 6'b100100, which covers 0x90 to 0x93. Any other opcode gives `illegal_o` in the cycle after the accepted start, and no byte is consumed.
- R3: A ModRM byte whose bits 7:6 equal 3, or whose bits 2:0 differ from 4, gives `illegal_o` in the cycle after that byte is consumed, and no further byte is consumed.
- R4: The scaled-index byte is split as follows. Bits 7:6 give `scale_o`. `index_reg_o` = {rex_x_i, bits 5:3}. `base_reg_o` = {rex_b_i, bits 2:0}.
- R5: When ModRM bits 7:6 are 0 and the scaled-index bits 2:0 are 5, whatever rex_b_i is, `no_base_o` is 1, `base_reg_o` is 0, and four displacement bytes follow.
- R6: When ModRM bits 7:6 are 0 and the base bits are not 5, no displacement byte is consumed, `disp_o` is 0 and `no_base_o` is 0.
- R7: With ModRM bits 7:6 equal to 1, one displacement byte is consumed and sign-extended. With bits 7:6 equal to 2, four bytes are consumed, least significant first, and the 32-bit value is sign-extended to `DISP_W`.
- R8: If `dest_reg_i` equals the decoded index register, or equals `mask_reg_i`, `illegal_o` rises in the cycle after the scaled-index byte is consumed, and no displacement byte is consumed.
- R9: `variant_o` has `rex_w_i` in bit 0, opcode bit 0 in bit 1 and the scale in bits 3:2.
- R10: `done_o` and `illegal_o` are one-cycle pulses that never coincide. `done_o` rises in the cycle after the last needed byte is consumed. During either pulse `byte_ready_o` is low. Field outputs are zero whenever `done_o` is low.
- R11: A new start is accepted in the cycle after a `done_o` or `illegal_o` pulse. Gaps in `byte_valid_i` only delay decoding and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin decoding; sampled while idle |
| opcode_i | input | 8 | Gather opcode byte |
| rex_w_i | input | 1 | Element width prefix bit |
| rex_x_i | input | 1 | Index register extension bit |
| rex_b_i | input | 1 | Base register extension bit |
| dest_reg_i | input | 4 | Destination vector register number |
| mask_reg_i | input | 4 | Mask vector register number |
| byte_valid_i | input | 1 | Byte stream valid |
| byte_i | input | 8 | Byte stream data |
| byte_ready_o | output | 1 | Byte stream ready |
| done_o | output | 1 | Fields valid, one cycle |
| illegal_o | output | 1 | Illegal encoding, one cycle |
| no_base_o | output | 1 | Address has no base register |
| base_reg_o | output | 4 | Base general register number |
| index_reg_o | output | 4 | Index vector register number |
| scale_o | output | 2 | Index scale exponent |
| disp_o | output | DISP_W | Sign-extended displacement |
| variant_o | output | 4 | Execution variant selector |

## Verification
The bench sweeps every opcode and every ModRM value. It also sweeps every scaled-index byte under each ModRM mode and each combination of prefix bits, with destination and mask numbers that sometimes collide. It feeds extra bytes after each instruction so that over-consumption shows up as a wrong byte count. A decoder that compared the full 4-bit base against 5 would consume no displacement when rex_b_i is set. A decoder that checked overlap only against the index would accept destination-equals-mask. A decoder that loaded the displacement most significant first, or sign-extended a short displacement from bit 31, would produce the wrong `disp_o`. Runs with gaps in `byte_valid_i` expose a counter that advances on invalid cycles.

// File: rtl/gvsib_pkg.sv
package gvsib_pkg;
  localparam int REG_W     = 4;
  localparam int RAW_BYTES = 4;
  localparam int RAW_W     = RAW_BYTES * 8;
  localparam int CNT_W     = $clog2(RAW_BYTES);
  localparam int LEN_W     = $clog2(RAW_BYTES + 1);

  localparam logic [5:0] GATHER_OPC_HI = 6'b100100;
  localparam logic [2:0] SIB_RM        = 3'd4;
  localparam logic [2:0] NO_BASE_CODE  = 3'd5;
  localparam logic [1:0] MOD_REG       = 2'd3;
  localparam logic [1:0] MOD_D8        = 2'd1;
  localparam logic [1:0] MOD_D32       = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MODRM, ST_SIB, ST_DISP, ST_DONE, ST_ILL
  } state_e;

  typedef struct packed {
    logic [1:0]       scale;
    logic [REG_W-1:0] index;
    logic [REG_W-1:0] base;
    logic             no_base;
  } sib_t;

  function automatic logic [LEN_W-1:0] disp_len(input logic [1:0] md,
                                                input logic [2:0] base_lo);
    unique case (md)
      MOD_D8:  disp_len = LEN_W'(1);
      MOD_D32: disp_len = LEN_W'(RAW_BYTES);
      default: disp_len = (base_lo == NO_BASE_CODE) ? LEN_W'(RAW_BYTES) : '0;
    endcase
  endfunction
endpackage

// File: rtl/gvsib_modrm_chk.sv
module gvsib_modrm_chk
  import gvsib_pkg::*;
(
  input  logic [7:0] modrm_i,
  output logic [1:0] mod_o,
  output logic       bad_o
);
  logic [2:0] rm;
  assign mod_o = modrm_i[7:6];
  assign rm    = modrm_i[2:0];
  // scaled-index byte is mandatory, register-direct form has no memory operand
  assign bad_o = (mod_o == MOD_REG) || (rm != SIB_RM);
endmodule

// File: rtl/gvsib_sib_split.sv
module gvsib_sib_split
  import gvsib_pkg::*;
(
  input  logic [7:0]       sib_i,
  input  logic [1:0]       mod_i,
  input  logic             rex_x_i,
  input  logic             rex_b_i,
  input  logic [REG_W-1:0] dest_i,
  input  logic [REG_W-1:0] mask_i,
  output sib_t             sib_o,
  output logic [LEN_W-1:0] len_o,
  output logic             overlap_o
);
  logic [2:0] base_lo;
  assign base_lo       = sib_i[2:0];
  assign sib_o.scale   = sib_i[7:6];
  assign sib_o.index   = {rex_x_i, sib_i[5:3]};
  assign sib_o.no_base = (mod_i == 2'd0) && (base_lo == NO_BASE_CODE);
  assign sib_o.base    = sib_o.no_base ? '0 : {rex_b_i, base_lo};
  assign len_o         = disp_len(mod_i, base_lo);
  assign overlap_o     = (dest_i == sib_o.index) || (dest_i == mask_i);
endmodule

// File: rtl/gvsib_disp_acc.sv
module gvsib_disp_acc
  import gvsib_pkg::*;
#(
  parameter int DISP_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic [7:0]        byte_i,
  input  logic              short_i,
  output logic [DISP_W-1:0] disp_o
);
  logic [RAW_W-1:0] raw_q;

  for (genvar g = 0; g < RAW_BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                raw_q[g*8 +: 8] <= '0;
      else if (clr_i)                             raw_q[g*8 +: 8] <= '0;
      else if (load_i && (pos_i == CNT_W'(g)))    raw_q[g*8 +: 8] <= byte_i;
    end
  end

  always_comb begin
    if (short_i) disp_o = {{(DISP_W-8){raw_q[7]}}, raw_q[7:0]};
    else         disp_o = {{(DISP_W-RAW_W){raw_q[RAW_W-1]}}, raw_q};
  end
endmodule

// File: rtl/gvsib_decoder.sv
module gvsib_decoder
  import gvsib_pkg::*;
#(
  parameter int DISP_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic              rex_w_i,
  input  logic              rex_x_i,
  input  logic              rex_b_i,
  input  logic [3:0]        dest_reg_i,
  input  logic [3:0]        mask_reg_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              byte_ready_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              no_base_o,
  output logic [3:0]        base_reg_o,
  output logic [3:0]        index_reg_o,
  output logic [1:0]        scale_o,
  output logic [DISP_W-1:0] disp_o,
  output logic [3:0]        variant_o
);
  state_e           st_q, st_d;
  logic             opc_lsb_q, rex_w_q, rex_x_q, rex_b_q;
  logic [REG_W-1:0] dest_q, mask_q;
  logic [1:0]       mod_q;
  sib_t             sib_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;

  logic             start_fire, modrm_fire, sib_fire, disp_fire;
  logic             is_gather, modrm_bad, overlap;
  logic [1:0]       mod_w;
  sib_t             sib_w;
  logic [LEN_W-1:0] len_w;
  logic [DISP_W-1:0] disp_w;
  logic             last_disp;

  assign byte_ready_o = (st_q == ST_MODRM) || (st_q == ST_SIB) || (st_q == ST_DISP);
  assign start_fire   = (st_q == ST_IDLE) && start_i;
  assign modrm_fire   = (st_q == ST_MODRM) && byte_valid_i;
  assign sib_fire     = (st_q == ST_SIB) && byte_valid_i;
  assign disp_fire    = (st_q == ST_DISP) && byte_valid_i;
  assign is_gather    = (opcode_i[7:2] == GATHER_OPC_HI);
  assign last_disp    = (LEN_W'(cnt_q) + LEN_W'(1)) == len_q;

  gvsib_modrm_chk u_modrm (
    .modrm_i (byte_i),
    .mod_o   (mod_w),
    .bad_o   (modrm_bad)
  );

  gvsib_sib_split u_sib (
    .sib_i     (byte_i),
    .mod_i     (mod_q),
    .rex_x_i   (rex_x_q),
    .rex_b_i   (rex_b_q),
    .dest_i    (dest_q),
    .mask_i    (mask_q),
    .sib_o     (sib_w),
    .len_o     (len_w),
    .overlap_o (overlap)
  );

  gvsib_disp_acc #(.DISP_W(DISP_W)) u_disp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_fire),
    .load_i  (disp_fire),
    .pos_i   (cnt_q),
    .byte_i  (byte_i),
    .short_i (mod_q == MOD_D8),
    .disp_o  (disp_w)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = is_gather ? ST_MODRM : ST_ILL;
      ST_MODRM: if (byte_valid_i) st_d = modrm_bad ? ST_ILL : ST_SIB;
      ST_SIB: if (byte_valid_i) begin
        if (overlap)          st_d = ST_ILL;
        else if (len_w == '0) st_d = ST_DONE;
        else                  st_d = ST_DISP;
      end
      ST_DISP:  if (byte_valid_i && last_disp) st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      opc_lsb_q <= 1'b0;
      rex_w_q   <= 1'b0;
      rex_x_q   <= 1'b0;
      rex_b_q   <= 1'b0;
      dest_q    <= '0;
      mask_q    <= '0;
      mod_q     <= '0;
      sib_q     <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
    end else begin
      st_q <= st_d;
      if (start_fire) begin
        opc_lsb_q <= opcode_i[0];
        rex_w_q   <= rex_w_i;
        rex_x_q   <= rex_x_i;
        rex_b_q   <= rex_b_i;
        dest_q    <= dest_reg_i;
        mask_q    <= mask_reg_i;
        mod_q     <= '0;
        sib_q     <= '0;
        len_q     <= '0;
      end
      if (modrm_fire) mod_q <= mod_w;
      if (sib_fire) begin
        sib_q <= sib_w;
        len_q <= len_w;
        cnt_q <= '0;
      end
      if (disp_fire) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign done_o      = (st_q == ST_DONE);
  assign illegal_o   = (st_q == ST_ILL);
  assign no_base_o   = done_o & sib_q.no_base;
  assign base_reg_o  = done_o ? sib_q.base  : '0;
  assign index_reg_o = done_o ? sib_q.index : '0;
  assign scale_o     = done_o ? sib_q.scale : '0;
  assign disp_o      = done_o ? disp_w : '0;
  assign variant_o   = done_o ? {sib_q.scale, opc_lsb_q, rex_w_q} : '0;
endmodule

// File: rtl/gvsib_decoder_chk.sv
module gvsib_decoder_chk #(
  parameter int DISP_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_ready_o,
  input logic              done_o,
  input logic              illegal_o,
  input logic              no_base_o,
  input logic [3:0]        base_reg_o,
  input logic [3:0]        index_reg_o,
  input logic [1:0]        scale_o,
  input logic [DISP_W-1:0] disp_o,
  input logic [3:0]        variant_o,
  input logic [3:0]        dest_q,
  input logic [3:0]        mask_q,
  input logic [1:0]        mod_q,
  input logic              modrm_fire,
  input logic              modrm_bad
);
  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || illegal_o) |-> !byte_ready_o);

  p_zero_fields_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (disp_o == '0 && variant_o == '0 && base_reg_o == '0 &&
                 index_reg_o == '0 && !no_base_o));

  p_bad_modrm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modrm_fire && modrm_bad) |=> illegal_o);

  p_no_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && no_base_o) |-> (base_reg_o == '0 && mod_q == 2'd0));

  p_no_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (index_reg_o != dest_q && mask_q != dest_q));

  p_variant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (variant_o[3:2] == scale_o));

  p_short_disp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mod_q == 2'd1) |-> ((&disp_o[DISP_W-1:7]) || !(|disp_o[DISP_W-1:7])));
endmodule

bind gvsib_decoder gvsib_decoder_chk #(.DISP_W(DISP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_ready_o (byte_ready_o),
  .done_o       (done_o),
  .illegal_o    (illegal_o),
  .no_base_o    (no_base_o),
  .base_reg_o   (base_reg_o),
  .index_reg_o  (index_reg_o),
  .scale_o      (scale_o),
  .disp_o       (disp_o),
  .variant_o    (variant_o),
  .dest_q       (dest_q),
  .mask_q       (mask_q),
  .mod_q        (mod_q),
  .modrm_fire   (modrm_fire),
  .modrm_bad    (modrm_bad)
);

// File: tb/gvsib_decoder_test.sv
module gvsib_decoder_test;
  localparam int DW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [7:0]    opcode_i = '0;
  logic          rex_w_i = 1'b0, rex_x_i = 1'b0, rex_b_i = 1'b0;
  logic [3:0]    dest_reg_i = '0, mask_reg_i = '0;
  logic          byte_valid_i = 1'b0;
  logic [7:0]    byte_i = '0;
  logic          byte_ready_o, done_o, illegal_o, no_base_o;
  logic [3:0]    base_reg_o, index_reg_o, variant_o;
  logic [1:0]    scale_o;
  logic [DW-1:0] disp_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit wd_fired = 1'b0;

  always #2 clk_i = ~clk_i;

  gvsib_decoder #(.DISP_W(DW)) uut (
    .clk_i, .rst_ni, .start_i, .opcode_i, .rex_w_i, .rex_x_i, .rex_b_i,
    .dest_reg_i, .mask_reg_i, .byte_valid_i, .byte_i, .byte_ready_o,
    .done_o, .illegal_o, .no_base_o, .base_reg_o, .index_reg_o,
    .scale_o, .disp_o, .variant_o
  );

  always @(posedge clk_i) cycles <= cycles + 1;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] opc, input bit w, input bit x, input bit b,
                     input logic [3:0] dest, input logic [3:0] mask,
                     input logic [7:0] modrm, input logic [7:0] sib,
                     input logic [31:0] dw, input bit gap);
    logic [7:0] s [8];
    bit e_ill, fin;
    int e_n, k, cyc;
    logic [3:0] e_idx, e_base;
    bit e_nb;
    logic [DW-1:0] e_disp;
    logic [1:0] md;
    string tag;
    s[0] = modrm; s[1] = sib; s[2] = dw[7:0]; s[3] = dw[15:8];
    s[4] = dw[23:16]; s[5] = dw[31:24]; s[6] = 8'hA5; s[7] = 8'h5A;
    md    = modrm[7:6];
    e_idx = {x, sib[5:3]};
    e_nb  = (md == 2'd0) && (sib[2:0] == 3'd5);
    e_base = e_nb ? 4'd0 : {b, sib[2:0]};
    e_disp = '0;
    e_ill = 1'b0;
    if (opc[7:2] != 6'b100100) begin
      e_ill = 1'b1; e_n = 0; tag = "R2";
    end else if (md == 2'd3 || modrm[2:0] != 3'd4) begin
      e_ill = 1'b1; e_n = 1; tag = "R3";
    end else if (dest == e_idx || dest == mask) begin
      e_ill = 1'b1; e_n = 2; tag = "R8";
    end else if (md == 2'd1) begin
      e_n = 3; tag = "R7"; e_disp = {{(DW-8){dw[7]}}, dw[7:0]};
    end else if (md == 2'd2) begin
      e_n = 6; tag = "R7"; e_disp = {{(DW-32){dw[31]}}, dw};
    end else if (e_nb) begin
      e_n = 6; tag = "R5"; e_disp = {{(DW-32){dw[31]}}, dw};
    end else begin
      e_n = 2; tag = "R6";
    end

    @(negedge clk_i);
    start_i = 1'b1; opcode_i = opc; rex_w_i = w; rex_x_i = x; rex_b_i = b;
    dest_reg_i = dest; mask_reg_i = mask; byte_valid_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    k = 0; cyc = 0; fin = 1'b0;
    while (!fin && cyc < 40) begin
      if (done_o || illegal_o) begin
        fin = 1'b1;
        chk({tag, " illegal"}, DW'(illegal_o), DW'(e_ill));
        chk({tag, " done R10"}, DW'(done_o), DW'(!e_ill));
        chk({tag, " bytes consumed R10"}, DW'(k), DW'(e_n));
        chk("R10 ready low at end", DW'(byte_ready_o), '0);
        if (!e_ill) begin
          chk("R4 index", DW'(index_reg_o), DW'(e_idx));
          chk("R4 scale", DW'(scale_o), DW'(sib[7:6]));
          chk("R5 no_base", DW'(no_base_o), DW'(e_nb));
          chk("R4 base", DW'(base_reg_o), DW'(e_base));
          chk({tag, " disp"}, disp_o, e_disp);
          chk("R9 variant", DW'(variant_o), DW'({sib[7:6], opc[0], w}));
        end else begin
          chk("R10 fields zero on illegal", disp_o | DW'(variant_o) | DW'(base_reg_o) |
              DW'(index_reg_o) | DW'(no_base_o), '0);
        end
      end else begin
        bit rdy, v;
        byte_i = s[k < 8 ? k : 7];
        byte_valid_i = !(gap && cyc[0]);
        rdy = byte_ready_o; v = byte_valid_i;
        @(negedge clk_i);
        if (rdy && v) k++;
        cyc++;
      end
    end
    byte_valid_i = 1'b0;
    if (!fin) chk({tag, " R11 completion timeout"}, '0, 1);
  endtask

  initial begin
    #6000000;
    wd_fired = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 ready after reset", DW'(byte_ready_o), '0);
    chk("R1 done after reset", DW'(done_o), '0);
    chk("R1 illegal after reset", DW'(illegal_o), '0);
    chk("R1 fields after reset", disp_o | DW'(variant_o) | DW'(base_reg_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: all opcodes
    for (int op = 0; op < 256 && !wd_fired; op++)
      run(8'(op), op[3], 1'b1, op[4], 4'd1, 4'd2, 8'h04, 8'h05 ^ 8'(op & 8'hC0), 32'h8000_0011, 1'b0);

    // R3: all ModRM values
    for (int m = 0; m < 256 && !wd_fired; m++)
      run(8'h91, m[0], 1'b0, m[1], 4'd3, 4'd4, 8'(m), 8'h4A, 32'h1234_56F0 + 32'(m), m[2]);

    // R4 R5 R6 R7 R8 R9 R11: every SIB byte, each mode, each prefix set
    for (int md = 0; md < 3 && !wd_fired; md++)
      for (int p = 0; p < 8; p++)
        for (int sb = 0; sb < 256; sb++) begin
          int i;
          i = sb + p * 256 + md * 2048;
          run(8'h90 + 8'(i & 3), p[0], p[1], p[2], 4'((i * 7) % 16), 4'((i * 5 + 3) % 16),
              {2'(md), 3'(i % 8), 3'd4}, 8'(sb), {8'(i), 8'(i * 3), 8'(~i), 8'(i * 13)},
              (i % 5) == 0);
        end

    // R7: short displacement sign sweep
    for (int d = 0; d < 256 && !wd_fired; d++)
      run(8'h93, 1'b1, 1'b0, 1'b1, 4'd9, 4'd10, 8'h44, 8'hD3, {24'hFFFF00, 8'(d)}, d[0]);

    if (wd_fired) chk("R11 watchdog", '0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule